// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block sits between a small 8-bit processor core and its external memory and peripheral pins. It turns each memory access that the core asks for into one external bus cycle. The low byte of a 13-bit address and the data byte share a single byte lane. The five upper address bits go out on their own lines. An address strobe tells outside logic when to latch the low address byte off the shared lane. A data strobe marks the data transfer. A direction line and an opcode-fetch flag qualify the cycle.

Every bus cycle runs for five oscillator clocks, in this order:

1. Address placed on the lane.
2. Address strobe pulse.
3. Lane turnaround.
4. Data strobe pulse.
5. Completion.

Because each cycle is five clocks long, the strobes repeat at no more than one fifth of the oscillator rate.

The core holds a request until it receives a one-clock acknowledge. On a read, the acknowledge arrives with the data. While the core reports a low-power wait or stop condition, the sequencer holds its position and no strobe appears. The shared lane is presented as separate output, output-enable and input signals, and the pad ring outside the block combines them into a tristate pin.

Top module: `mux_bus_sequencer`

## Requirements
- R1: While reset is asserted, and after it is released, the outputs are as follows: address strobe low, data strobe low, fetch flag low, acknowledge low, direction line high (read), and lane output enable low (lane released).
- R2: The sequencer accepts a request on the first clock edge at which the request is high, the sequencer is idle and low power is off. The acknowledge is high for exactly one clock, namely the fifth clock after acceptance.
- R3: In phases 1 and 2 the lane output enable is high and the lane output carries address bits 7:0. From phase 1 until the next cycle begins, the upper address lines carry address bits 12:8.
- R4: The address strobe is high in phase 2 only, for exactly one clock.
- R5: The data strobe is high in phase 4 only, for exactly one clock, for both reads and writes.
- R6: The direction line is low from phase 1 through phase 5 of a write and high throughout a read. It is high again once the cycle ends.
- R7: In a write, the lane is released in phase 3. In phase 4 the lane output enable is high and the lane output carries the write byte.
- R8: In a read, the lane is released in phases 3 to 5. The lane input is captured at the clock edge that ends the data strobe, and the captured byte appears on the read-data output together with the acknowledge.
- R9: In a fetch cycle, the fetch flag is high in phases 1 to 4, so it overlaps the data strobe. It is low in every other clock.
- R10: While low power is high, no strobe or acknowledge is produced and no new cycle starts. A cycle that is in progress holds its phase and resumes where it stopped once low power falls.
- R11: Asserting reset in the middle of a cycle brings the outputs to the R1 state at once. No acknowledge follows for that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| low_pwr | input | 1 | Core is in wait or stop mode |
| req | input | 1 | Access request, held until acknowledge |
| req_we | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | Access is an opcode fetch |
| req_addr | input | 13 | Access address |
| req_wdata | input | 8 | Write data |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Read data, valid with ack |
| lane_o | output | 8 | Shared lane output value |
| lane_oe | output | 1 | Shared lane output enable |
| lane_i | input | 8 | Shared lane input value |
| addr_hi | output | 5 | Address bits 12:8 |
| as_o | output | 1 | Address strobe |
| ds_o | output | 1 | Data strobe |
| rd_wr_n | output | 1 | 1 = read, 0 = write |
| fetch_o | output | 1 | Opcode fetch in progress |

## Verification
The assertions take the following for granted:
- The core keeps `req` and its qualifiers steady from the moment it raises the request until the acknowledge.
- External logic presents a stable byte on `lane_i` around the clock edge that ends the data strobe.

The bench changes every input on the falling clock edge. It sets the lane input before the request and drops the request in the clock that carries the acknowledge. Low power is raised and lowered only on falling edges, so the freeze check compares whole clocks.

// File: rtl/busseq_pkg.sv
package busseq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_ASTB = 3'd2,
    PH_TURN = 3'd3,
    PH_DSTB = 3'd4,
    PH_DONE = 3'd5
  } phase_e;
endpackage

// File: rtl/busseq_phase_ctrl.sv
module busseq_phase_ctrl
  import busseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_req,
  input  logic   hold,
  output phase_e phase,
  output logic   accept,
  output logic   sample_en
);
  phase_e phase_q;
  phase_e phase_d;

  assign accept    = (phase_q == PH_IDLE) && start_req && !hold;
  assign sample_en = (phase_q == PH_DSTB) && !hold;
  assign phase     = phase_q;

  always_comb begin
    phase_d = phase_q;
    if (!hold) begin
      unique case (phase_q)
        PH_IDLE: if (start_req) phase_d = PH_ADDR;
        PH_ADDR: phase_d = PH_ASTB;
        PH_ASTB: phase_d = PH_TURN;
        PH_TURN: phase_d = PH_DSTB;
        PH_DSTB: phase_d = PH_DONE;
        PH_DONE: phase_d = PH_IDLE;
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  // R10
  lp_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(phase_q));
endmodule

// File: rtl/busseq_req_hold.sv
module busseq_req_hold #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              we_in,
  input  logic              fetch_in,
  input  logic [DATA_W-1:0] wdata_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic              we_q,
  output logic              fetch_q,
  output logic [DATA_W-1:0] wdata_q
);
  logic [ADDR_W-1:0] addr_d;
  logic              we_d;
  logic              fetch_d;
  logic [DATA_W-1:0] wdata_d;

  always_comb begin
    addr_d  = addr_q;
    we_d    = we_q;
    fetch_d = fetch_q;
    wdata_d = wdata_q;
    if (load) begin
      addr_d  = addr_in;
      we_d    = we_in;
      fetch_d = fetch_in;
      wdata_d = wdata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      fetch_q <= 1'b0;
      wdata_q <= '0;
    end else begin
      addr_q  <= addr_d;
      we_q    <= we_d;
      fetch_q <= fetch_d;
      wdata_q <= wdata_d;
    end
  end
endmodule

// File: rtl/busseq_lane_drv.sv
module busseq_lane_drv
  import busseq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic              we,
  input  logic [DATA_W-1:0] addr_lo,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sample_en,
  input  logic [DATA_W-1:0] lane_i,
  output logic [DATA_W-1:0] lane_o,
  output logic              lane_oe,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    lane_o  = '0;
    lane_oe = 1'b0;
    unique case (phase)
      PH_ADDR, PH_ASTB: begin
        lane_o  = addr_lo;
        lane_oe = 1'b1;
      end
      PH_DSTB: begin
        if (we) begin
          lane_o  = wdata;
          lane_oe = 1'b1;
        end
      end
      default: begin
        lane_o  = '0;
        lane_oe = 1'b0;
      end
    endcase
  end

  always_comb begin
    rdata_d = rdata;
    if (sample_en && !we) rdata_d = lane_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_d;
  end

  // R7
  turn_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TURN) |-> !lane_oe);
endmodule

// File: rtl/mux_bus_sequencer.sv
module mux_bus_sequencer
  import busseq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     low_pwr,
  input  logic                     req,
  input  logic                     req_we,
  input  logic                     req_fetch,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     ack,
  output logic [DATA_W-1:0]        rdata,
  output logic [DATA_W-1:0]        lane_o,
  output logic                     lane_oe,
  input  logic [DATA_W-1:0]        lane_i,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic                     as_o,
  output logic                     ds_o,
  output logic                     rd_wr_n,
  output logic                     fetch_o
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic        rst_meta;
  logic        rst_s;
  phase_e      phase;
  logic        accept;
  logic        sample_en;
  logic [ADDR_W-1:0] addr_q;
  logic        we_q;
  logic        fetch_q;
  logic [DATA_W-1:0] wdata_q;
  logic        busy;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  busseq_phase_ctrl u_phase (
    .clk       (clk),
    .rst_n     (rst_s),
    .start_req (req),
    .hold      (low_pwr),
    .phase     (phase),
    .accept    (accept),
    .sample_en (sample_en)
  );

  busseq_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_s),
    .load     (accept),
    .addr_in  (req_addr),
    .we_in    (req_we),
    .fetch_in (req_fetch),
    .wdata_in (req_wdata),
    .addr_q   (addr_q),
    .we_q     (we_q),
    .fetch_q  (fetch_q),
    .wdata_q  (wdata_q)
  );

  busseq_lane_drv #(.DATA_W(DATA_W)) u_lane (
    .clk       (clk),
    .rst_n     (rst_s),
    .phase     (phase),
    .we        (we_q),
    .addr_lo   (addr_q[DATA_W-1:0]),
    .wdata     (wdata_q),
    .sample_en (sample_en),
    .lane_i    (lane_i),
    .lane_o    (lane_o),
    .lane_oe   (lane_oe),
    .rdata     (rdata)
  );

  assign busy    = (phase != PH_IDLE);
  assign addr_hi = addr_q[ADDR_W-1 -: HI_W];
  assign as_o    = (phase == PH_ASTB) && !low_pwr;
  assign ds_o    = (phase == PH_DSTB) && !low_pwr;
  assign ack     = (phase == PH_DONE) && !low_pwr;
  assign rd_wr_n = !(busy && we_q);
  assign fetch_o = fetch_q && (phase inside {PH_ADDR, PH_ASTB, PH_TURN, PH_DSTB});

  // R4
  as_single_chk: assert property (@(posedge clk) disable iff (!rst_s)
    as_o |=> !as_o);
  // R5
  ds_single_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ds_o |=> !ds_o);
  // R2
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ack |=> !ack);
  // R3
  as_lane_chk: assert property (@(posedge clk) disable iff (!rst_s)
    as_o |-> lane_oe);
  // R7
  ds_dir_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ds_o |-> (lane_oe == !rd_wr_n));
  // R9
  ds_fetch_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(ds_o) && !low_pwr |-> !fetch_o);
endmodule

// File: tb/mux_bus_sequencer_bench.sv
module mux_bus_sequencer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        low_pwr;
  logic        req;
  logic        req_we;
  logic        req_fetch;
  logic [12:0] req_addr;
  logic [7:0]  req_wdata;
  logic        ack;
  logic [7:0]  rdata;
  logic [7:0]  lane_o;
  logic        lane_oe;
  logic [7:0]  lane_i;
  logic [4:0]  addr_hi;
  logic        as_o;
  logic        ds_o;
  logic        rd_wr_n;
  logic        fetch_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_bus_sequencer u_mux_bus_sequencer (
    .clk(clk), .rst_n(rst_n), .low_pwr(low_pwr), .req(req), .req_we(req_we),
    .req_fetch(req_fetch), .req_addr(req_addr), .req_wdata(req_wdata),
    .ack(ack), .rdata(rdata), .lane_o(lane_o), .lane_oe(lane_oe),
    .lane_i(lane_i), .addr_hi(addr_hi), .as_o(as_o), .ds_o(ds_o),
    .rd_wr_n(rd_wr_n), .fetch_o(fetch_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(!as_o, {tag, " as"}, 32'(as_o), 0);
    chk(!ds_o, {tag, " ds"}, 32'(ds_o), 0);
    chk(!fetch_o, {tag, " fetch"}, 32'(fetch_o), 0);
    chk(!ack, {tag, " ack"}, 32'(ack), 0);
    chk(rd_wr_n, {tag, " rw"}, 32'(rd_wr_n), 1);
    chk(!lane_oe, {tag, " oe"}, 32'(lane_oe), 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; low_pwr = 1'b0; req = 1'b0; req_we = 1'b0; req_fetch = 1'b0;
    req_addr = '0; req_wdata = '0; lane_i = '0;
    repeat (3) @(negedge clk);
    chk_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_idle("R1 after reset");
  endtask

  // Full cycle check; called on a falling edge.
  task automatic run_cycle(input logic [12:0] a, input bit we, input bit fe,
                           input logic [7:0] wd, input logic [7:0] li);
    lane_i = li; req_addr = a; req_we = we; req_fetch = fe; req_wdata = wd;
    req = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      @(posedge clk); @(negedge clk);
      chk(as_o == (k == 2), "R4 as phase", 32'(as_o), 32'(k == 2));
      chk(ds_o == (k == 4), "R5 ds phase", 32'(ds_o), 32'(k == 4));
      chk(ack == (k == 5), "R2 ack phase", 32'(ack), 32'(k == 5));
      chk(rd_wr_n == !we, "R6 rw", 32'(rd_wr_n), 32'(!we));
      chk(fetch_o == (fe && k <= 4), "R9 fetch", 32'(fetch_o), 32'(fe && k <= 4));
      chk(addr_hi == a[12:8], "R3 addr_hi", 32'(addr_hi), 32'(a[12:8]));
      if (k <= 2) begin
        chk(lane_oe && lane_o == a[7:0], "R3 addr lane", 32'(lane_o), 32'(a[7:0]));
      end else if (k == 4 && we) begin
        chk(lane_oe && lane_o == wd, "R7 write lane", 32'(lane_o), 32'(wd));
      end else begin
        chk(!lane_oe, "R7 R8 lane released", 32'(lane_oe), 0);
      end
      if (k == 5) begin
        if (!we) chk(rdata == li, "R8 rdata", 32'(rdata), 32'(li));
        req = 1'b0;
        lane_i = ~li;
      end
    end
    @(posedge clk); @(negedge clk);
    chk(!ack, "R2 ack one clock", 32'(ack), 0);
    chk(rd_wr_n, "R6 rw back high", 32'(rd_wr_n), 1);
    if (!we) chk(rdata == li, "R8 rdata held", 32'(rdata), 32'(li));
  endtask

  task automatic test_lowpwr_idle();
    low_pwr = 1'b1; req = 1'b1; req_we = 1'b0; req_addr = 13'h0A5;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); @(negedge clk);
      chk(!as_o && !ds_o && !ack && !lane_oe, "R10 no start in low power",
          {as_o, ds_o, ack, lane_oe}, 0);
    end
    req = 1'b0; low_pwr = 1'b0;
    @(negedge clk);
  endtask

  task automatic test_lowpwr_freeze();
    lane_i = 8'h3C; req_addr = 13'h1E42; req_we = 1'b0; req_fetch = 1'b1; req = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk(as_o, "R4 as before freeze", 32'(as_o), 1);
    low_pwr = 1'b1;
    #1;
    chk(!as_o, "R10 as suppressed", 32'(as_o), 0);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      chk(!as_o && !ds_o && !ack, "R10 frozen", {as_o, ds_o, ack}, 0);
      chk(lane_oe && lane_o == 8'h42, "R10 phase held", 32'(lane_o), 32'h42);
    end
    low_pwr = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(!lane_oe && !as_o, "R10 resumes at turnaround", {lane_oe, as_o}, 0);
    @(posedge clk); @(negedge clk);
    chk(ds_o && fetch_o, "R10 R9 ds after resume", {ds_o, fetch_o}, 3);
    @(posedge clk); @(negedge clk);
    chk(ack && rdata == 8'h3C, "R10 R8 ack after resume", {ack, rdata}, {1'b1, 8'h3C});
    req = 1'b0; req_fetch = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic test_reset_mid();
    req_addr = 13'h0777; req_we = 1'b1; req_wdata = 8'h99; req = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); @(negedge clk);
    end
    chk(ds_o, "R11 in data phase", 32'(ds_o), 1);
    rst_n = 1'b0; req = 1'b0;
    #1;
    chk_idle("R11 mid-cycle reset");
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); @(negedge clk);
      chk(!ack && !as_o, "R11 no ack after reset", {ack, as_o}, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    run_cycle(13'h1234, 1'b1, 1'b0, 8'h5A, 8'h00);  // write
    run_cycle(13'h0AC3, 1'b0, 1'b0, 8'h00, 8'hE7);  // read
    run_cycle(13'h1FFF, 1'b0, 1'b1, 8'h00, 8'h81);  // fetch read
    run_cycle(13'h0000, 1'b1, 1'b0, 8'hFF, 8'h11);  // write at zero
    test_lowpwr_idle();
    test_lowpwr_freeze();
    test_reset_mid();
    run_cycle(13'h1100, 1'b0, 1'b0, 8'h00, 8'h6D);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule